// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers eight interrupt request lines from peripherals and drives a single maskable request signal to a processor. A rising edge on any line is latched as pending. Pending lines that are not masked compete by fixed priority: line 0 is the most urgent and line 7 the least.

When the processor pulses the acknowledge input, the block returns an 8-bit vector for the winning line. The winning level then moves from the pending set to the in-service set. While a level is in service, requests at that level or below are held back. A request of strictly higher priority can still interrupt, so service routines can nest. Software ends a service routine by writing the end-of-interrupt code to the command port, which retires the most urgent in-service level.

A small byte-wide I/O port interface gives access to two registers: the command port, and the per-line mask register. Software can read the mask, change single bits and write it back.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `int_req` is low, the mask register reads FFh (all lines disabled) and the in-service register reads 00h.
- R2: Writing port 21h loads the mask register, and reading port 21h returns it. Bit i of the mask controls line i: 1 disables the line and 0 enables it.
- R3: A rising edge on `irq_in[i]` latches line i as pending. A line held high is not latched again. A masked pending line stays latched and raises `int_req` once it is unmasked.
- R4: `int_req` is high only when some unmasked line is pending and no in-service level has equal or higher priority than the most urgent such line.
- R5: A cycle with `int_ack` high while `int_req` is high does three things. On the next cycle it raises `vec_valid` for one cycle with `vec_out` = 08h + the lowest-numbered unmasked pending line. It clears that line's pending bit. It sets that line's bit in the in-service register.
- R6: While a level is in service, newly latched requests of the same or lower priority keep `int_req` low.
- R7: A request of strictly higher priority than every in-service level raises `int_req` and can be acknowledged, which nests the in-service levels.
- R8: Writing 20h to port 20h (end of interrupt) clears the lowest-numbered set bit of the in-service register.
- R9: A write to port 20h with any value other than 20h leaves the in-service register unchanged.
- R10: An acknowledge while `int_req` is low returns vector 0Fh with `vec_valid`, and changes neither the pending nor the in-service state.
- R11: With `io_rd` high, port 20h reads the in-service register (bit i is level i). Any address other than 20h or 21h reads 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Peripheral request lines, bit i is level i |
| int_req | output | 1 | Maskable interrupt request to the processor |
| int_ack | input | 1 | Acknowledge from the processor, one cycle per acknowledge |
| vec_out | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | One-cycle strobe marking a new `vec_out` |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid while `io_rd` is high |

## Verification
The bench builds the block with its default parameters. These give eight lines, a 16-bit port address, a command port at 20h, a mask port at 21h, an end-of-interrupt code of 20h and a vector base of 08h. With these values the bench can reach every vector from 08h to 0Fh, including the spurious 0Fh answer. The stimulus also covers a masked request that is released later, two levels nested in service, and end-of-interrupt writes that retire the levels one at a time in priority order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    // Which register an I/O access selects
    typedef enum logic [1:0] {
        PSEL_NONE = 2'd0,
        PSEL_CMD  = 2'd1,
        PSEL_MASK = 2'd2
    } port_sel_e;

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] prev,
    output logic [WIDTH-1:0] rise
);
    // One detector per line
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        assign rise[g] = cur[g] & ~prev[g];
    end
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int WIDTH = 8,
    parameter int IDX_W = 3
) (
    input  logic [WIDTH-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // The lowest-numbered set bit wins, so scan from the top down
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int                NUM_LINES = 8,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'h21,
    parameter logic [DATA_W-1:0] EOI_CODE  = 'h20,
    parameter logic [DATA_W-1:0] VEC_BASE  = 'h08
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic                 int_req,
    input  logic                 int_ack,
    output logic [DATA_W-1:0]    vec_out,
    output logic                 vec_valid,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_rd,
    input  logic                 io_wr,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [DATA_W-1:0]    io_rdata
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [DATA_W-1:0] SPUR_VEC = VEC_BASE + DATA_W'(NUM_LINES - 1);

    typedef struct packed {
        logic [NUM_LINES-1:0] irq_prev;
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] isr;
        logic [NUM_LINES-1:0] mask;
        logic [DATA_W-1:0]    vec;
        logic                 vec_valid;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_LINES-1:0] pend_q, isr_q, mask_q;
    assign pend_q = st_q.pend;
    assign isr_q  = st_q.isr;
    assign mask_q = st_q.mask;

    logic [NUM_LINES-1:0] rise, eligible, grant, eoi_clr;
    logic                 win_found, isr_found;
    logic [IDX_W-1:0]     win_idx, isr_idx;
    port_sel_e            psel;
    logic                 eoi_cmd, mask_wr;

    irq_edge_detect #(.WIDTH(NUM_LINES)) u_edge (
        .cur  (irq_in),
        .prev (st_q.irq_prev),
        .rise (rise)
    );

    assign eligible = st_q.pend & ~st_q.mask;

    irq_first_set #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_pick_req (
        .vec   (eligible),
        .found (win_found),
        .idx   (win_idx)
    );

    irq_first_set #(.WIDTH(NUM_LINES), .IDX_W(IDX_W)) u_pick_isr (
        .vec   (st_q.isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    // Request only when the winner outranks every in-service level
    assign int_req = win_found && (!isr_found || (win_idx < isr_idx));

    always_comb begin
        if (io_addr == CMD_ADDR)       psel = PSEL_CMD;
        else if (io_addr == MASK_ADDR) psel = PSEL_MASK;
        else                           psel = PSEL_NONE;
    end

    assign eoi_cmd = io_wr && (psel == PSEL_CMD) && (io_wdata == EOI_CODE);
    assign mask_wr = io_wr && (psel == PSEL_MASK);

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            case (psel)
                PSEL_CMD:  io_rdata = DATA_W'(st_q.isr);
                PSEL_MASK: io_rdata = DATA_W'(st_q.mask);
                default:   io_rdata = '0;
            endcase
        end
    end

    always_comb begin
        st_d           = st_q;
        st_d.irq_prev  = irq_in;
        st_d.vec_valid = 1'b0;
        grant          = '0;
        eoi_clr        = '0;
        if (int_ack) begin
            st_d.vec_valid = 1'b1;
            if (int_req) begin
                grant[win_idx] = 1'b1;
                st_d.vec       = VEC_BASE + DATA_W'(win_idx);
            end else begin
                st_d.vec = SPUR_VEC;
            end
        end
        if (eoi_cmd && isr_found) begin
            eoi_clr[isr_idx] = 1'b1;
        end
        st_d.pend = (st_q.pend & ~grant) | rise;
        st_d.isr  = (st_q.isr & ~eoi_clr) | grant;
        if (mask_wr) begin
            st_d.mask = io_wdata[NUM_LINES-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{irq_prev: '0, pend: '0, isr: '0, mask: '1,
                      vec: '0, vec_valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_out   = st_q.vec;
    assign vec_valid = st_q.vec_valid;

endmodule

// File: rtl/irq_prio_ctrl_sva.sv
module irq_prio_ctrl_sva #(
    parameter int                NUM_LINES = 8,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 'h20,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 'h21,
    parameter logic [DATA_W-1:0] EOI_CODE  = 'h20,
    parameter logic [DATA_W-1:0] VEC_BASE  = 'h08
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 int_req,
    input logic                 int_ack,
    input logic [DATA_W-1:0]    vec_out,
    input logic                 vec_valid,
    input logic [ADDR_W-1:0]    io_addr,
    input logic                 io_wr,
    input logic [DATA_W-1:0]    io_wdata,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] isr,
    input logic [NUM_LINES-1:0] mask
);
    localparam logic [DATA_W-1:0] TOP_VEC = VEC_BASE + DATA_W'(NUM_LINES - 1);

    logic eoi_w, bad_cmd_w, mask_w;
    assign eoi_w     = io_wr && (io_addr == CMD_ADDR) && (io_wdata == EOI_CODE);
    assign bad_cmd_w = io_wr && (io_addr == CMD_ADDR) && (io_wdata != EOI_CODE);
    assign mask_w    = io_wr && (io_addr == MASK_ADDR);

    assert_vec_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_out >= VEC_BASE && vec_out <= TOP_VEC));

    assert_req_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (|(pend & ~mask)));

    assert_ack_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req && !eoi_w) |=>
            ($countones(isr) == $past($countones(isr)) + 1) && vec_valid);

    assert_eoi_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_w && !int_ack && (isr != '0)) |=>
            ($countones(isr) + 1 == $past($countones(isr))));

    assert_bad_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_cmd_w && !int_ack) |=> $stable(isr));

    assert_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req && !eoi_w) |=>
            (vec_valid && vec_out == TOP_VEC && $stable(isr)));

    assert_masked_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_w |=> ((pend & $past(pend & mask)) == $past(pend & mask)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_sva #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR),
    .MASK_ADDR (MASK_ADDR),
    .EOI_CODE  (EOI_CODE),
    .VEC_BASE  (VEC_BASE)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .int_req   (int_req),
    .int_ack   (int_ack),
    .vec_out   (vec_out),
    .vec_valid (vec_valid),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .pend      (pend_q),
    .isr       (isr_q),
    .mask      (mask_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_in = '0;
    logic        int_req;
    logic        int_ack = 1'b0;
    logic [7:0]  vec_out;
    logic        vec_valid;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    irq_prio_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .int_req(int_req),
        .int_ack(int_ack), .vec_out(vec_out), .vec_valid(vec_valid),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    // Driver: pushes the expected vector, then pulses acknowledge
    task automatic do_ack(input logic [7:0] exp, input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        int_ack = 1'b1;
        @(negedge clk);
        int_ack = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic chk_req(input string req, input logic exp);
        @(negedge clk);
        check(req, {7'd0, int_req}, {7'd0, exp});
    endtask

    // Monitor: pops and compares each vector the design presents
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R5 unexpected vector", vec_out, 8'hxx);
            end else begin
                check(tag_q.pop_front(), vec_out, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R5 actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_req("R1 int_req after reset", 1'b0);
        io_read(16'h0021, rd); check("R1 mask after reset", rd, 8'hFF);
        io_read(16'h0020, rd); check("R1 in-service after reset", rd, 8'h00);
        // R2 mask port
        io_write(16'h0021, 8'hA5);
        io_read(16'h0021, rd); check("R2 mask readback", rd, 8'hA5);
        io_read(16'h0033, rd); check("R11 unmapped port reads zero", rd, 8'h00);
        // R2 masked line (bit3) does not request; R3 latched while masked
        io_write(16'h0021, 8'h08);
        set_irq(8'h08);
        chk_req("R2 masked line keeps int_req low", 1'b0);
        io_write(16'h0021, 8'h00);
        chk_req("R3 unmasked pending raises int_req", 1'b1);
        do_ack(8'h0B, "R5 vector for line 3");
        io_read(16'h0020, rd); check("R11 in-service after ack", rd, 8'h08);
        chk_req("R3 held level not relatched", 1'b0);
        // R6 lower and equal priority held back
        set_irq(8'h28);
        chk_req("R6 lower priority blocked", 1'b0);
        set_irq(8'h20);
        set_irq(8'h28);
        chk_req("R6 equal priority blocked", 1'b0);
        // R7 nesting
        set_irq(8'h2A);
        chk_req("R7 higher priority raises int_req", 1'b1);
        do_ack(8'h09, "R7 nested vector line 1");
        io_read(16'h0020, rd); check("R7 nested in-service", rd, 8'h0A);
        chk_req("R6 lower pending still blocked", 1'b0);
        // R8 / R9 end of interrupt
        io_write(16'h0020, 8'h20);
        io_read(16'h0020, rd); check("R8 eoi clears level 1", rd, 8'h08);
        chk_req("R6 line 3 equal to in-service", 1'b0);
        io_write(16'h0020, 8'h55);
        io_read(16'h0020, rd); check("R9 non-eoi command ignored", rd, 8'h08);
        io_write(16'h0020, 8'h20);
        io_read(16'h0020, rd); check("R8 eoi clears level 3", rd, 8'h00);
        chk_req("R4 pending line 3 requests", 1'b1);
        do_ack(8'h0B, "R5 relatched line 3 vector");
        io_write(16'h0020, 8'h20);
        do_ack(8'h0D, "R5 line 5 vector");
        io_read(16'h0020, rd); check("R5 line 5 in service", rd, 8'h20);
        io_write(16'h0020, 8'h20);
        chk_req("R4 nothing pending", 1'b0);
        // R10 spurious acknowledge
        do_ack(8'h0F, "R10 spurious vector");
        io_read(16'h0020, rd); check("R10 in-service unchanged", rd, 8'h00);
        chk_req("R10 int_req stays low", 1'b0);
        // R5 simultaneous requests resolved by priority
        set_irq(8'h00);
        set_irq(8'h44);
        do_ack(8'h0A, "R5 line 2 beats line 6");
        io_write(16'h0020, 8'h20);
        do_ack(8'h0E, "R5 line 6 after eoi");
        io_write(16'h0020, 8'h20);
        io_read(16'h0020, rd); check("R8 all retired", rd, 8'h00);
        repeat (3) @(negedge clk);
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R5 missing vectors actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule